// File: doc/BRIEF.md
# OSD Raster Position and Row Timing Generator

This block produces the display-window timing for an on-screen-display overlay. It runs on the dot clock, which is nominally 320 times the horizontal line rate. For example, a 32 kHz line rate gives a 10.24 MHz dot clock. It watches the horizontal and vertical flyback pulses and reports a set of position values from them. These are the character column being drawn, the dot inside the character cell, the character row, the font line within the glyph, and a display-enable qualifier. A downstream font lookup and colouring stage uses these values directly.

Each frame holds a fixed number of character rows. Each row takes its own height in scan lines and its own double-width flag from a configuration input. The block samples that input at the moment the row begins, and it names the row it will need next on a request-index output. A row taller than the 16-line font stretches the font lines over its height. A double-width row draws only the even character positions, each at twice the width, so every line still carries 240 active dots. The horizontal window starts a fixed dot offset after the horizontal flyback edge, plus a programmable step offset. The first row starts a fixed line offset after the vertical flyback edge, plus a programmable step offset. A new vertical flyback always ends the current frame at once.

Top module: `osd_raster_gen`

## Requirements
- R1: After reset, disp_en_o is 0, and col_o, dot_o, row_o, font_line_o and cfg_idx_o are all 0.
- R2: Call the clock edge that first samples hflb_i high (after it was low) edge 0. disp_en_o is then high exactly for the states following edges hs through hs+239, where hs = 50 + 4*hdelay_i (47 fixed dots plus a 3-dot phase allowance). A new hflb_i rising edge drops disp_en_o on the next cycle.
- R3: In a single-width row, with x = active dot number (0..239), col_o = x/10 and dot_o = x mod 10.
- R4: In a double-width row (row flag 1), col_o = 2*floor(x/20) and dot_o = floor(x/2) mod 10, over the same 240 dots.
- R5: Count the hflb_i rising edges after a vflb_i rising edge. Row 0 starts on edge number 1 + 4*vdelay_i. Before that edge, and before any vertical flyback after reset, disp_en_o stays 0.
- R6: Rows follow one another in index order, each lasting its configured number of lines. row_height_i and row_dbl_i are sampled on the edge that starts a row. cfg_idx_o equals row_o+1 while rows are running and 0 otherwise.
- R7: font_line_o = floor(k*16/H), where k is the line number within the row and H is the row height. A height value below 16 is treated as 16.
- R8: After the last line of row 14 (the 15th row), disp_en_o stays 0 until the next vflb_i rising edge.
- R9: A vflb_i rising edge forces disp_en_o to 0 on the next cycle, even mid-line or mid-frame, and restarts the line count. If an hflb_i rising edge falls in the same cycle, that edge is not counted as a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hflb_i | input | 1 | Horizontal flyback pulse, rising edge marks line start |
| vflb_i | input | 1 | Vertical flyback pulse, rising edge marks frame start |
| hdelay_i | input | 6 | Horizontal start step count, 4 dots per step |
| vdelay_i | input | 6 | Vertical start step count, 4 lines per step |
| row_height_i | input | 6 | Height in scan lines of the requested row |
| row_dbl_i | input | 1 | Double-width flag of the requested row |
| cfg_idx_o | output | 4 | Index of the row whose configuration is sampled next |
| col_o | output | 5 | Character column |
| dot_o | output | 4 | Dot within the character cell |
| row_o | output | 4 | Character row |
| font_line_o | output | 4 | Font line within the glyph |
| disp_en_o | output | 1 | Display window qualifier |

## Verification
The frame-start edge and the line-start edge can arrive in the same clock cycle. The bench provokes this by raising both flyback inputs on the same cycle. It then judges, line by line, that the first row appears exactly 1 + 4*vdelay_i further lines later, which shows the coincident line edge was not counted. A second collision is a vertical flyback raised in the middle of the active dots. There, the enable must fall on the very next sample and the following lines must restart from row 0.

// File: rtl/osd_raster_pkg.sv
package osd_raster_pkg;

   // vertical sequencer phases
   typedef enum logic [1:0] {
      VS_IDLE = 2'd0,   // frame finished or never started
      VS_WAIT = 2'd1,   // counting lines toward the first row
      VS_ROWS = 2'd2    // character rows in progress
   } vstate_e;

endpackage

// File: rtl/osd_edge_rise.sv
module osd_edge_rise #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] rise
);

   logic [N-1:0] din_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) din_q <= '0;
      else        din_q <= din;
   end

   assign rise = din & ~din_q;

endmodule

// File: rtl/osd_hgen.sv
module osd_hgen #(
   parameter int CELL_W      = 10,
   parameter int ACTIVE_DOTS = 240,
   parameter int HCNT_W      = 10,
   parameter int COL_W       = 5,
   parameter int DOT_W       = 4,
   parameter int DBL_EN      = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic [HCNT_W-1:0] hstart,
   input  logic              dbl,
   output logic              active,
   output logic [COL_W-1:0]  col,
   output logic [DOT_W-1:0]  dot
);

   localparam int              X_W      = $clog2(ACTIVE_DOTS);
   localparam logic [X_W-1:0]  X_LAST   = X_W'(ACTIVE_DOTS - 1);
   localparam logic [DOT_W-1:0] DOT_LAST = DOT_W'(CELL_W - 1);

   logic [HCNT_W-1:0] hcnt;
   logic [X_W-1:0]    xpos;
   logic              ph;
   logic              wide;
   logic              step;
   logic [COL_W-1:0]  col_inc;

   // dots since the last line-start edge, saturating; parked at all-ones after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               hcnt <= '1;
      else if (line_start)      hcnt <= '0;
      else if (hcnt != '1)      hcnt <= hcnt + HCNT_W'(1);
   end

   generate
      if (DBL_EN != 0) begin : g_wide
         // half-rate phase: cell dot advances every other clock in wide rows
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    ph <= 1'b0;
            else if (line_start || !active) ph <= 1'b0;
            else                           ph <= ~ph;
         end
         assign wide = dbl;
      end else begin : g_narrow
         assign ph   = 1'b1;
         assign wide = 1'b0 & dbl;
      end
   endgenerate

   assign step    = ~wide | ph;
   assign col_inc = wide ? COL_W'(2) : COL_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         xpos   <= '0;
         col    <= '0;
         dot    <= '0;
      end else if (line_start) begin
         active <= 1'b0;
      end else if (!active) begin
         if (hcnt == hstart - HCNT_W'(1)) begin
            active <= 1'b1;
            xpos   <= '0;
            col    <= '0;
            dot    <= '0;
         end
      end else begin
         if (xpos == X_LAST) active <= 1'b0;
         else                xpos   <= xpos + X_W'(1);
         if (step) begin
            if (dot == DOT_LAST) begin
               dot <= '0;
               col <= col + col_inc;
            end else begin
               dot <= dot + DOT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/osd_vgen.sv
module osd_vgen
   import osd_raster_pkg::*;
#(
   parameter int NUM_ROWS = 15,
   parameter int FONT_H   = 16,
   parameter int CH_W     = 6,
   parameter int VLN_W    = 8,
   parameter int ROW_W    = 4,
   parameter int FL_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             line_start,
   input  logic [VLN_W-1:0] vstart,
   input  logic [CH_W-1:0]  cfg_h,
   input  logic             cfg_dbl,
   output logic             rows_on,
   output logic [ROW_W-1:0] row,
   output logic [FL_W-1:0]  fline,
   output logic             dbl,
   output logic [ROW_W-1:0] cfg_idx
);

   localparam logic [CH_W-1:0]  H_MIN    = CH_W'(FONT_H);
   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);

   vstate_e          state;
   logic [VLN_W-1:0] vline;
   logic [CH_W-1:0]  lrow;
   logic [CH_W-1:0]  cur_h;
   logic [CH_W:0]    acc;
   logic [CH_W:0]    acc_sum;
   logic [CH_W-1:0]  h_eff;

   assign h_eff   = (cfg_h < H_MIN) ? H_MIN : cfg_h;
   // remainder of lrow*FONT_H / cur_h, advanced by FONT_H per line
   assign acc_sum = acc + (CH_W+1)'(FONT_H);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= VS_IDLE;
         vline <= '0;
         row   <= '0;
         lrow  <= '0;
         acc   <= '0;
         fline <= '0;
         cur_h <= H_MIN;
         dbl   <= 1'b0;
      end else if (frame_start) begin
         state <= VS_WAIT;
         vline <= '0;
      end else if (line_start) begin
         unique case (state)
            VS_WAIT: begin
               if (vline + VLN_W'(1) == vstart) begin
                  state <= VS_ROWS;
                  row   <= '0;
                  lrow  <= '0;
                  acc   <= '0;
                  fline <= '0;
                  cur_h <= h_eff;
                  dbl   <= cfg_dbl;
               end else begin
                  vline <= vline + VLN_W'(1);
               end
            end
            VS_ROWS: begin
               if (lrow == cur_h - CH_W'(1)) begin
                  if (row == ROW_LAST) begin
                     state <= VS_IDLE;
                  end else begin
                     row   <= row + ROW_W'(1);
                     lrow  <= '0;
                     acc   <= '0;
                     fline <= '0;
                     cur_h <= h_eff;
                     dbl   <= cfg_dbl;
                  end
               end else begin
                  lrow <= lrow + CH_W'(1);
                  if (acc_sum >= {1'b0, cur_h}) begin
                     acc   <= acc_sum - {1'b0, cur_h};
                     fline <= fline + FL_W'(1);
                  end else begin
                     acc <= acc_sum;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign rows_on = (state == VS_ROWS);
   assign cfg_idx = rows_on ? row + ROW_W'(1) : '0;

endmodule

// File: rtl/osd_raster_gen.sv
module osd_raster_gen #(
   parameter int CELL_W      = 10,
   parameter int FONT_H      = 16,
   parameter int ACTIVE_DOTS = 240,
   parameter int NUM_ROWS    = 15,
   parameter int HFIX_DOTS   = 47,
   parameter int PHASE_DOTS  = 3,
   parameter int HSTEP       = 4,
   parameter int VFIX_LINES  = 1,
   parameter int VSTEP       = 4,
   parameter int DLY_W       = 6,
   parameter int CH_W        = 6,
   parameter int DBL_EN      = 1,
   localparam int COLS       = ACTIVE_DOTS / CELL_W,
   localparam int COL_W      = $clog2(COLS + 1),
   localparam int DOT_W      = $clog2(CELL_W),
   localparam int FL_W       = $clog2(FONT_H),
   localparam int ROW_W      = $clog2(NUM_ROWS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hflb_i,
   input  logic             vflb_i,
   input  logic [DLY_W-1:0] hdelay_i,
   input  logic [DLY_W-1:0] vdelay_i,
   input  logic [CH_W-1:0]  row_height_i,
   input  logic             row_dbl_i,
   output logic [ROW_W-1:0] cfg_idx_o,
   output logic [COL_W-1:0] col_o,
   output logic [DOT_W-1:0] dot_o,
   output logic [ROW_W-1:0] row_o,
   output logic [FL_W-1:0]  font_line_o,
   output logic             disp_en_o
);

   localparam int HSTART_MAX = HFIX_DOTS + PHASE_DOTS + HSTEP * ((1 << DLY_W) - 1);
   localparam int HCNT_W     = $clog2(HSTART_MAX + ACTIVE_DOTS + 2);
   localparam int VSTART_MAX = VFIX_LINES + VSTEP * ((1 << DLY_W) - 1);
   localparam int VLN_W      = $clog2(VSTART_MAX + 1);

   generate
      if (ACTIVE_DOTS % CELL_W != 0) begin : g_chk_cols
         $error("ACTIVE_DOTS must be a whole number of cells");
      end
      if (FONT_H >= (1 << CH_W)) begin : g_chk_font
         $error("row height field too narrow for FONT_H");
      end
      if (NUM_ROWS < 1 || HFIX_DOTS + PHASE_DOTS < 1 || VFIX_LINES < 1) begin : g_chk_min
         $error("row count and fixed offsets must be positive");
      end
   endgenerate

   logic [1:0]        rise;
   logic              line_start;
   logic              frame_start;
   logic [HCNT_W-1:0] hstart;
   logic [VLN_W-1:0]  vstart;
   logic              h_active;
   logic              rows_on;
   logic              row_dbl;

   osd_edge_rise #(.N(2)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({vflb_i, hflb_i}),
      .rise (rise)
   );

   assign line_start  = rise[0];
   assign frame_start = rise[1];

   assign hstart = HCNT_W'(HFIX_DOTS + PHASE_DOTS) + HCNT_W'(HSTEP) * HCNT_W'(hdelay_i);
   assign vstart = VLN_W'(VFIX_LINES) + VLN_W'(VSTEP) * VLN_W'(vdelay_i);

   osd_hgen #(
      .CELL_W     (CELL_W),
      .ACTIVE_DOTS(ACTIVE_DOTS),
      .HCNT_W     (HCNT_W),
      .COL_W      (COL_W),
      .DOT_W      (DOT_W),
      .DBL_EN     (DBL_EN)
   ) u_hgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_start(line_start),
      .hstart    (hstart),
      .dbl       (row_dbl),
      .active    (h_active),
      .col       (col_o),
      .dot       (dot_o)
   );

   osd_vgen #(
      .NUM_ROWS(NUM_ROWS),
      .FONT_H  (FONT_H),
      .CH_W    (CH_W),
      .VLN_W   (VLN_W),
      .ROW_W   (ROW_W),
      .FL_W    (FL_W)
   ) u_vgen (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .line_start (line_start),
      .vstart     (vstart),
      .cfg_h      (row_height_i),
      .cfg_dbl    (row_dbl_i),
      .rows_on    (rows_on),
      .row        (row_o),
      .fline      (font_line_o),
      .dbl        (row_dbl),
      .cfg_idx    (cfg_idx_o)
   );

   assign disp_en_o = h_active & rows_on;

endmodule

// File: rtl/osd_raster_gen_chk.sv
module osd_raster_gen_chk #(
   parameter int CELL_W   = 10,
   parameter int COLS     = 24,
   parameter int NUM_ROWS = 15,
   parameter int COL_W    = 5,
   parameter int DOT_W    = 4,
   parameter int ROW_W    = 4,
   parameter int FL_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hflb_i,
   input logic             vflb_i,
   input logic [ROW_W-1:0] cfg_idx_o,
   input logic [COL_W-1:0] col_o,
   input logic [DOT_W-1:0] dot_o,
   input logic [ROW_W-1:0] row_o,
   input logic [FL_W-1:0]  font_line_o,
   input logic             disp_en_o
);

   logic             h_q, v_q, en_q;
   logic [DOT_W-1:0] dot_q;
   logic [ROW_W-1:0] row_q;
   logic [FL_W-1:0]  fl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_q <= 1'b0; v_q <= 1'b0; en_q <= 1'b0;
         dot_q <= '0; row_q <= '0; fl_q <= '0;
      end else begin
         h_q <= hflb_i; v_q <= vflb_i; en_q <= disp_en_o;
         dot_q <= dot_o; row_q <= row_o; fl_q <= font_line_o;
      end
   end

   assert_hflb_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hflb_i && !h_q) |=> !disp_en_o);

   assert_vflb_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (vflb_i && !v_q) |=> !disp_en_o);

   // R3/R4: inside a window the cell dot holds, steps by one, or wraps
   assert_dot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_en_o && en_q) |-> ((dot_o == dot_q) || (dot_o == dot_q + DOT_W'(1)) ||
                               (dot_o == '0 && dot_q == DOT_W'(CELL_W - 1))));

   assert_col_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      disp_en_o |-> (col_o < COL_W'(COLS)));

   assert_row_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_en_o && en_q) |-> (row_o == row_q && font_line_o == fl_q));

   assert_cfg_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      disp_en_o |-> (cfg_idx_o == row_o + ROW_W'(1)));

   assert_row_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      disp_en_o |-> (row_o < ROW_W'(NUM_ROWS)));

endmodule

bind osd_raster_gen osd_raster_gen_chk #(
   .CELL_W  (CELL_W),
   .COLS    (COLS),
   .NUM_ROWS(NUM_ROWS),
   .COL_W   (COL_W),
   .DOT_W   (DOT_W),
   .ROW_W   (ROW_W),
   .FL_W    (FL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hflb_i     (hflb_i),
   .vflb_i     (vflb_i),
   .cfg_idx_o  (cfg_idx_o),
   .col_o      (col_o),
   .dot_o      (dot_o),
   .row_o      (row_o),
   .font_line_o(font_line_o),
   .disp_en_o  (disp_en_o)
);

// File: tb/osd_raster_gen_bench.sv
module osd_raster_gen_bench;

   localparam int NROWS = 15;
   // columns: hdelay, vdelay, row height, double-width flag
   localparam int VEC [4][4] = '{
      '{0,  0, 16, 0},
      '{5,  1, 22, 1},
      '{63, 0, 25, 0},
      '{3,  0,  8, 0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hflb_i = 1'b0;
   logic       vflb_i = 1'b0;
   logic [5:0] hdelay_i = '0;
   logic [5:0] vdelay_i = '0;
   logic [5:0] row_height_i = 6'd16;
   logic       row_dbl_i = 1'b0;
   logic [3:0] cfg_idx_o;
   logic [4:0] col_o;
   logic [3:0] dot_o;
   logic [3:0] row_o;
   logic [3:0] font_line_o;
   logic       disp_en_o;

   int n_chk = 0;
   int n_bad = 0;
   int rh [NROWS];
   bit rd [NROWS];
   int hd = 0, vd = 0;
   int jline = 0;
   bit vseen = 0;
   bit prev_act = 0;
   int prev_r = 0;

   always #4 clk = ~clk;

   osd_raster_gen u_osd_raster_gen (
      .clk(clk), .rst_n(rst_n), .hflb_i(hflb_i), .vflb_i(vflb_i),
      .hdelay_i(hdelay_i), .vdelay_i(vdelay_i),
      .row_height_i(row_height_i), .row_dbl_i(row_dbl_i),
      .cfg_idx_o(cfg_idx_o), .col_o(col_o), .dot_o(dot_o), .row_o(row_o),
      .font_line_o(font_line_o), .disp_en_o(disp_en_o)
   );

   function automatic int eff(input int h);
      return (h < 16) ? 16 : h;
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic vsync();
      @(negedge clk);
      vflb_i = 1'b1;
      repeat (4) @(negedge clk);
      vflb_i = 1'b0;
      vseen = 1; jline = 0; prev_act = 0;
   endtask

   task automatic run_line(input bit with_v, input int cut);
      int idx, hs, len, d, r, x;
      bit act, en_exp;
      string tag;
      @(negedge clk);
      check("R6", "cfg_idx", cfg_idx_o, prev_act ? prev_r + 1 : 0);
      idx = cfg_idx_o;
      if (idx < NROWS) begin
         row_height_i = 6'(rh[idx]);
         row_dbl_i = rd[idx];
      end
      hflb_i = 1'b1;
      if (with_v) vflb_i = 1'b1;
      if (with_v) begin jline = 0; vseen = 1; end
      else if (vseen) jline++;
      act = 0; r = 0; d = 0;
      if (!with_v && vseen && jline >= 1 + 4 * vd) begin
         d = jline - (1 + 4 * vd);
         while (r < NROWS && d >= eff(rh[r])) begin
            d -= eff(rh[r]);
            r++;
         end
         act = (r < NROWS);
      end
      hs = 50 + 4 * hd;
      len = hs + 250;
      for (int n = 0; n < len; n++) begin
         @(negedge clk);
         en_exp = act && n >= hs && n < hs + 240 && (cut < 0 || n <= cut);
         if (cut >= 0 && n > cut) tag = "R9";
         else if (with_v) tag = "R9";
         else if (act) tag = "R2";
         else if (vseen && r >= NROWS) tag = "R8";
         else tag = "R5";
         check(tag, "disp_en", int'(disp_en_o), int'(en_exp));
         if (en_exp && disp_en_o) begin
            x = n - hs;
            if (rd[r]) begin
               check("R4", "col", col_o, 2 * (x / 20));
               check("R4", "dot", dot_o, (x / 2) % 10);
            end else begin
               check("R3", "col", col_o, x / 10);
               check("R3", "dot", dot_o, x % 10);
            end
            check("R6", "row", row_o, r);
            check("R7", "font_line", font_line_o, (d * 16) / eff(rh[r]));
         end
         if (n == 7) begin
            hflb_i = 1'b0;
            if (with_v) vflb_i = 1'b0;
         end
         if (n == cut) vflb_i = 1'b1;
         if (cut >= 0 && n == cut + 4) vflb_i = 1'b0;
      end
      if (cut >= 0) begin
         jline = 0; vseen = 1; prev_act = 0;
      end else begin
         prev_act = act; prev_r = r;
      end
   endtask

   task automatic set_uniform(input int h, input bit dbl);
      for (int i = 0; i < NROWS; i++) begin
         rh[i] = h;
         rd[i] = dbl;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      set_uniform(16, 0);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", "disp_en", disp_en_o, 0);
      check("R1", "col", col_o, 0);
      check("R1", "dot", dot_o, 0);
      check("R1", "row", row_o, 0);
      check("R1", "font_line", font_line_o, 0);
      check("R1", "cfg_idx", cfg_idx_o, 0);

      // R5: line edges with no vertical flyback yet show nothing
      repeat (2) run_line(0, -1);

      // table walk: delays, heights (incl. clamped 8 -> 16 for R7), width modes
      for (int v = 0; v < 4; v++) begin
         hd = VEC[v][0];
         vd = VEC[v][1];
         set_uniform(VEC[v][2], VEC[v][3] != 0);
         hdelay_i = 6'(hd);
         vdelay_i = 6'(vd);
         vsync();
         repeat (30) run_line(0, -1);
      end

      // R6/R8: full frame of mixed heights and widths, then blank lines
      hd = 0; vd = 0;
      hdelay_i = '0; vdelay_i = '0;
      for (int i = 0; i < NROWS; i++) begin
         rh[i] = (i % 2 != 0) ? 19 : 16;
         rd[i] = (i % 2 != 0);
      end
      vsync();
      repeat (265) run_line(0, -1);

      // R9: vertical flyback in the middle of the active dots
      set_uniform(16, 0);
      vsync();
      repeat (4) run_line(0, -1);
      run_line(0, 100);
      repeat (3) run_line(0, -1);

      // R9: both flyback edges in the same cycle, vstart = 5 lines
      vd = 1;
      vdelay_i = 6'd1;
      run_line(1, -1);
      repeat (6) run_line(0, -1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule